// File: doc/BRIEF.md
# Page-Walk and Memory-Operation Sequencer

This block is the control state machine in front of a data cache that is shared with a hardware page-table walker. While idle it looks at three request inputs: an instruction-TLB miss, a data-TLB miss and a load/store request. From these it works out which page walks are needed and in what order. During each walk it passes the cache to the walker through an arbiter select. When a walk ends it pulses the write enable of the TLB that missed, or raises that TLB's fault. After that it replays, finishes or aborts the memory operation. The stall stays high until the whole sequence is over.

An instruction-TLB miss never cancels a load or store that is already in the memory stage. The walker's own cache accesses overwrite the original lookup, so any operation that waited behind a walk is sent into the cache again after the walk. A committed flag marks the window in which a memory operation is in progress. Interrupts are refused while it is high. An interrupt may cut short a lone instruction-TLB walk only before the TLB has been written.

The walker, the TLBs and the cache arrays are outside the block. Their results come back as one-cycle pulses: a leaf found, a walk fault, and the cache finishing the operation.

Top module: `walk_seq`

## Requirements
- R1: After reset, `stall`, `walker_sel` and `committed` are low and the block is idle.
- R2: A memory request with no TLB miss goes straight to the busy state with no walk. `stall` and `committed` stay high until `cache_done`, and `stall` is low on the following cycle.
- R3: On a data-TLB miss (legal only together with `mem_req`), `walker_sel` is high during the walk. A `walk_leaf` pulses `dtlb_we` in the same cycle, `replay` pulses for exactly one cycle after that, and the block then waits for `cache_done`.
- R4: A fault during a data-TLB walk pulses `dtlb_fault` and `mem_abort` with no `dtlb_we` and no `replay`, and `stall` is low on the next cycle.
- R5: An instruction-TLB miss with no memory request runs one walk. It ends with an `itlb_we` pulse on a leaf or an `itlb_fault` pulse on a fault, and then releases the stall with no `replay` and no `committed`.
- R6: An instruction-TLB miss with a memory request runs the instruction walk first. Whether it writes or faults, the operation is then replayed and finished, and `mem_abort` never pulses.
- R7: When both TLBs miss, the data walk comes first (its `dtlb_we` precedes `itlb_we`). A data leaf is followed by the instruction walk, and the operation is finished even if that walk faults. A data fault aborts everything with no instruction walk.
- R8: `committed` rises when the operation enters the cache (replay or direct start) and falls after `cache_done`. `irq_take` is never high while `committed` is high.
- R9: During a lone instruction-TLB walk, `irq_req` with no walk result in that cycle pulses `irq_take`, drops the walk with no `itlb_we`, and leaves the block idle next cycle. If `walk_leaf` arrives in the same cycle, the write wins and the interrupt is taken on the next idle cycle.
- R10: In the idle state `irq_req` pulses `irq_take`, and request inputs in that cycle are ignored.
- R11: `walker_sel` is low in the replay and busy states, and `replay` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| itlb_miss | input | 1 | Instruction-TLB miss, sampled when idle |
| dtlb_miss | input | 1 | Data-TLB miss, sampled when idle |
| mem_req | input | 1 | Load/store present in the memory stage, sampled when idle |
| walk_leaf | input | 1 | Walker found a leaf entry (pulse) |
| walk_fault | input | 1 | Walker detected a fault (pulse) |
| cache_done | input | 1 | Cache finished the memory operation (pulse) |
| irq_req | input | 1 | Pending interrupt |
| stall | output | 1 | Hold the pipeline |
| walker_sel | output | 1 | Arbiter select: walker owns the cache |
| dtlb_we | output | 1 | Data-TLB write enable (pulse) |
| itlb_we | output | 1 | Instruction-TLB write enable (pulse) |
| dtlb_fault | output | 1 | Data-side page fault (pulse) |
| itlb_fault | output | 1 | Instruction-side page fault (pulse) |
| replay | output | 1 | Re-issue the original access into the cache (pulse) |
| mem_abort | output | 1 | Drop the memory operation (pulse) |
| committed | output | 1 | Memory operation in progress |
| irq_take | output | 1 | Interrupt accepted this cycle |

## Verification
The assertions check on every cycle that interrupts are never taken while an operation is committed, that a TLB write happens only while the walker holds the cache, and that replay is a one-cycle pulse. They also check that an abort frees the stall on the next cycle, that a finished instruction walk with a waiting operation leads to a replay, and that an interrupt leaves the block idle. Only the bench scenarios can show the full per-case outcome: which pulses appear for each combination of misses and walk results, that the data walk comes before the instruction walk, and how a simultaneous leaf and interrupt resolve.

// File: rtl/walk_seq_pkg.sv
// Shared types for the page-walk sequencer.
package walk_seq_pkg;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DWALK  = 3'd1,
        ST_IWALK  = 3'd2,
        ST_REPLAY = 3'd3,
        ST_BUSY   = 3'd4
    } seq_state_t;

    // Decoded start request.
    typedef struct packed {
        logic valid;
        logic need_d;
        logic need_i;
        logic has_mem;
    } start_req_t;

endpackage

// File: rtl/walk_seq_decode.sv
// Classifies the three request inputs into a start request.
// Assumes a data-TLB miss only comes with a memory request. A lone data-TLB
// miss is illegal. It is caught by an assertion and contributes no walk.
module walk_seq_decode
    import walk_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       itlb_miss,
    input  logic       dtlb_miss,
    input  logic       mem_req,
    output start_req_t req
);

    // Combinational classification of the incoming request.
    always_comb begin
        req.need_d  = dtlb_miss & mem_req;
        req.need_i  = itlb_miss;
        req.has_mem = mem_req;
        req.valid   = mem_req | itlb_miss;
    end

    // R3
    input_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dtlb_miss |-> mem_req);

endmodule

// File: rtl/walk_seq_fsm.sv
// Orders the walks, issues the TLB writes and faults, and replays, finishes
// or aborts the memory operation. Walk results and cache completion are
// one-cycle pulses. If leaf and fault come together, the fault wins.
module walk_seq_fsm
    import walk_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  start_req_t req,
    input  logic       start_block,
    input  logic       walk_leaf,
    input  logic       walk_fault,
    input  logic       cache_done,
    input  logic       irq_abort,
    output logic       in_idle,
    output logic       iwalk_solo,
    output logic       stall,
    output logic       walker_sel,
    output logic       dtlb_we,
    output logic       itlb_we,
    output logic       dtlb_fault,
    output logic       itlb_fault,
    output logic       replay,
    output logic       mem_abort,
    output logic       op_start,
    output logic       op_done
);

    seq_state_t state, nxt;
    logic       pend_i, pend_i_n;
    logic       pend_m, pend_m_n;

    // State and pending-work registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pend_i <= 1'b0;
            pend_m <= 1'b0;
        end else begin
            state  <= nxt;
            pend_i <= pend_i_n;
            pend_m <= pend_m_n;
        end
    end

    // Status decoded from the state.
    always_comb begin
        in_idle    = (state == ST_IDLE);
        stall      = (state != ST_IDLE);
        walker_sel = (state == ST_DWALK) || (state == ST_IWALK);
        iwalk_solo = (state == ST_IWALK) && !pend_m;
        replay     = (state == ST_REPLAY);
    end

    // Next state and result pulses.
    always_comb begin
        nxt        = state;
        pend_i_n   = pend_i;
        pend_m_n   = pend_m;
        dtlb_we    = 1'b0;
        itlb_we    = 1'b0;
        dtlb_fault = 1'b0;
        itlb_fault = 1'b0;
        mem_abort  = 1'b0;
        op_start   = 1'b0;
        op_done    = 1'b0;
        case (state)
            ST_IDLE: begin
                if (req.valid && !start_block) begin
                    if (req.need_d) begin
                        nxt      = ST_DWALK;
                        pend_i_n = req.need_i;
                        pend_m_n = 1'b1;
                    end else if (req.need_i) begin
                        nxt      = ST_IWALK;
                        pend_i_n = 1'b0;
                        pend_m_n = req.has_mem;
                    end else begin
                        nxt      = ST_BUSY;
                        op_start = 1'b1;
                        pend_m_n = 1'b1;
                    end
                end
            end
            ST_DWALK: begin
                if (walk_fault) begin
                    dtlb_fault = 1'b1;
                    mem_abort  = 1'b1;
                    nxt        = ST_IDLE;
                    pend_i_n   = 1'b0;
                    pend_m_n   = 1'b0;
                end else if (walk_leaf) begin
                    dtlb_we = 1'b1;
                    if (pend_i) begin
                        nxt      = ST_IWALK;
                        pend_i_n = 1'b0;
                    end else begin
                        nxt      = ST_REPLAY;
                        op_start = 1'b1;
                    end
                end
            end
            ST_IWALK: begin
                if (walk_fault || walk_leaf) begin
                    itlb_we    = !walk_fault;
                    itlb_fault = walk_fault;
                    if (pend_m) begin
                        nxt      = ST_REPLAY;
                        op_start = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end else if (irq_abort) begin
                    nxt = ST_IDLE;
                end
            end
            ST_REPLAY: nxt = ST_BUSY;
            ST_BUSY: begin
                if (cache_done) begin
                    op_done  = 1'b1;
                    nxt      = ST_IDLE;
                    pend_m_n = 1'b0;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // R3
    dwe_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dtlb_we |-> walker_sel);

    // R11
    replay_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        replay |=> !replay);

    // R4
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_abort |=> !stall);

    // R6
    ifinish_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walker_sel && !iwalk_solo && (itlb_we || itlb_fault)) |=> replay);

    // R7
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dtlb_we |-> !itlb_we);

endmodule

// File: rtl/walk_seq_commit.sv
// Holds the committed flag and decides when an interrupt may be taken.
// Interrupts are accepted when idle, or during a lone instruction walk in a
// cycle that brings no walk result. They are refused while committed is high.
module walk_seq_commit (
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic op_done,
    input  logic in_idle,
    input  logic iwalk_solo,
    input  logic walk_end,
    input  logic irq_req,
    output logic committed,
    output logic irq_take,
    output logic irq_abort
);

    // Committed flag: set on entry to the cache, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)        committed <= 1'b0;
        else if (op_start) committed <= 1'b1;
        else if (op_done)  committed <= 1'b0;
    end

    // Interrupt acceptance window.
    always_comb begin
        irq_abort = irq_req && iwalk_solo && !walk_end;
        irq_take  = !committed && ((irq_req && in_idle) || irq_abort);
    end

    // R8
    commit_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        committed |-> !in_idle);

    // R8
    commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !committed);

    // R9
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> in_idle);

endmodule

// File: rtl/walk_seq.sv
// Top level of the page-walk and memory-operation sequencer. It connects the
// request decoder, the sequencing FSM and the commit/interrupt tracker.
module walk_seq
    import walk_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic itlb_miss,
    input  logic dtlb_miss,
    input  logic mem_req,
    input  logic walk_leaf,
    input  logic walk_fault,
    input  logic cache_done,
    input  logic irq_req,
    output logic stall,
    output logic walker_sel,
    output logic dtlb_we,
    output logic itlb_we,
    output logic dtlb_fault,
    output logic itlb_fault,
    output logic replay,
    output logic mem_abort,
    output logic committed,
    output logic irq_take
);

    start_req_t req;
    logic       in_idle, iwalk_solo, op_start, op_done, irq_abort;

    walk_seq_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .itlb_miss (itlb_miss),
        .dtlb_miss (dtlb_miss),
        .mem_req   (mem_req),
        .req       (req)
    );

    walk_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .start_block (irq_take),
        .walk_leaf   (walk_leaf),
        .walk_fault  (walk_fault),
        .cache_done  (cache_done),
        .irq_abort   (irq_abort),
        .in_idle     (in_idle),
        .iwalk_solo  (iwalk_solo),
        .stall       (stall),
        .walker_sel  (walker_sel),
        .dtlb_we     (dtlb_we),
        .itlb_we     (itlb_we),
        .dtlb_fault  (dtlb_fault),
        .itlb_fault  (itlb_fault),
        .replay      (replay),
        .mem_abort   (mem_abort),
        .op_start    (op_start),
        .op_done     (op_done)
    );

    walk_seq_commit u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_start   (op_start),
        .op_done    (op_done),
        .in_idle    (in_idle),
        .iwalk_solo (iwalk_solo),
        .walk_end   (walk_leaf | walk_fault),
        .irq_req    (irq_req),
        .committed  (committed),
        .irq_take   (irq_take),
        .irq_abort  (irq_abort)
    );

endmodule

// File: tb/walk_seq_bench.sv
`timescale 1ns/1ps
module walk_seq_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic itlb_miss = 0, dtlb_miss = 0, mem_req = 0;
    logic walk_leaf = 0, walk_fault = 0, cache_done = 0, irq_req = 0;
    logic stall, walker_sel, dtlb_we, itlb_we, dtlb_fault, itlb_fault;
    logic replay, mem_abort, committed, irq_take;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    walk_seq u_walk_seq (
        .clk(clk), .rst_n(rst_n), .itlb_miss(itlb_miss), .dtlb_miss(dtlb_miss),
        .mem_req(mem_req), .walk_leaf(walk_leaf), .walk_fault(walk_fault),
        .cache_done(cache_done), .irq_req(irq_req), .stall(stall),
        .walker_sel(walker_sel), .dtlb_we(dtlb_we), .itlb_we(itlb_we),
        .dtlb_fault(dtlb_fault), .itlb_fault(itlb_fault), .replay(replay),
        .mem_abort(mem_abort), .committed(committed), .irq_take(irq_take)
    );

    // Bits: [11] itlb, [10] dtlb, [9] mem, [8] data walk faults, [7] instr walk
    // faults | expected seen: [6] dtlb_we [5] itlb_we [4] dtlb_fault
    // [3] itlb_fault [2] replay [1] mem_abort [0] committed
    localparam int NVEC = 10;
    localparam logic [11:0] VEC [NVEC] = '{
        12'b00100_0000001,
        12'b01100_1000101,
        12'b01110_0010010,
        12'b10000_0100000,
        12'b10001_0001000,
        12'b10100_0100101,
        12'b10101_0001101,
        12'b11100_1100101,
        12'b11101_1001101,
        12'b11110_0010010
    };

    function automatic string tag_of(int k);
        case (k)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3, 4: return "R5";
            5, 6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Plays one scenario, acting as the walker and the cache.
    task automatic run_vec(input int k);
        logic [6:0] seen = '0;
        int walk_n = 0, wait_n = 0, dwe_at = -1, iwe_at = -1;
        bit ended = 0;
        logic [11:0] v = VEC[k];
        @(negedge clk);
        itlb_miss = v[11]; dtlb_miss = v[10]; mem_req = v[9];
        @(negedge clk);
        itlb_miss = 0; dtlb_miss = 0; mem_req = 0;
        for (int c = 0; c < 40; c++) begin
            walk_leaf = 0; walk_fault = 0; cache_done = 0;
            if (!stall) begin ended = 1; break; end
            if (walker_sel) begin
                wait_n++;
                if (wait_n == 2) begin
                    if (walk_n == 0 && v[10]) walk_fault = v[8];
                    else walk_fault = v[7];
                    walk_leaf = !walk_fault;
                    walk_n++;
                    wait_n = 0;
                end
            end
            if (committed && !replay) cache_done = 1;
            #1;
            if (dtlb_we) begin seen[6] = 1; dwe_at = c; end
            if (itlb_we) begin seen[5] = 1; iwe_at = c; end
            if (dtlb_fault) seen[4] = 1;
            if (itlb_fault) seen[3] = 1;
            if (replay) seen[2] = 1;
            if (mem_abort) seen[1] = 1;
            if (committed) seen[0] = 1;
            @(negedge clk);
        end
        walk_leaf = 0; walk_fault = 0; cache_done = 0;
        chk({tag_of(k), " end"}, {31'd0, ended}, 32'd1);
        chk({tag_of(k), " outcome"}, {25'd0, seen}, {25'd0, v[6:0]});
        if (seen[6] && seen[5])
            chk("R7 order", {31'd0, dwe_at < iwe_at}, 32'd1);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hang expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 stall", {31'd0, stall}, 0);
        chk("R1 walker_sel", {31'd0, walker_sel}, 0);
        chk("R1 committed", {31'd0, committed}, 0);

        for (int k = 0; k < NVEC; k++) run_vec(k);

        // R2 stall held while cache is slow, R8 interrupt refused
        @(negedge clk); mem_req = 1;
        @(negedge clk); mem_req = 0;
        repeat (3) @(negedge clk);
        irq_req = 1; #1;
        chk("R2 stall held", {31'd0, stall}, 1);
        chk("R2 committed held", {31'd0, committed}, 1);
        chk("R11 walker_sel busy", {31'd0, walker_sel}, 0);
        chk("R8 irq refused", {31'd0, irq_take}, 0);
        @(negedge clk); cache_done = 1;
        @(negedge clk); cache_done = 0;
        chk("R2 stall released", {31'd0, stall}, 0);
        chk("R8 committed cleared", {31'd0, committed}, 0);
        // R10 interrupt taken when idle, request ignored
        mem_req = 1; #1;
        chk("R10 irq taken idle", {31'd0, irq_take}, 1);
        @(negedge clk); mem_req = 0; irq_req = 0;
        chk("R10 request ignored", {31'd0, stall}, 0);

        // R9 interrupt aborts a lone instruction walk before the write
        itlb_miss = 1;
        @(negedge clk); itlb_miss = 0; irq_req = 1; #1;
        chk("R9 irq aborts walk", {31'd0, irq_take}, 1);
        chk("R9 no itlb write", {31'd0, itlb_we}, 0);
        @(negedge clk); irq_req = 0;
        chk("R9 idle after abort", {31'd0, stall}, 0);

        // R9 leaf and interrupt together: the write wins
        itlb_miss = 1;
        @(negedge clk); itlb_miss = 0; walk_leaf = 1; irq_req = 1; #1;
        chk("R9 leaf wins write", {31'd0, itlb_we}, 1);
        chk("R9 irq deferred", {31'd0, irq_take}, 0);
        @(negedge clk); walk_leaf = 0; #1;
        chk("R9 irq next instr", {31'd0, irq_take}, 1);
        @(negedge clk); irq_req = 0;

        // R11 replay pulse and arbiter select in replay
        dtlb_miss = 1; mem_req = 1;
        @(negedge clk); dtlb_miss = 0; mem_req = 0; walk_leaf = 1;
        @(negedge clk); walk_leaf = 0; #1;
        chk("R11 replay high", {31'd0, replay}, 1);
        chk("R11 walker_sel replay", {31'd0, walker_sel}, 0);
        @(negedge clk); #1;
        chk("R11 replay single", {31'd0, replay}, 0);
        @(negedge clk); cache_done = 1;
        @(negedge clk); cache_done = 0;
        chk("R3 done after replay", {31'd0, stall}, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule